// File: doc/BRIEF.md
# Signed Multiply-Accumulate Register Unit

This block multiplies two signed 16-bit operands and adds the product into a 42-bit signed accumulator. Software sees the accumulator as a pair of 32-bit words. The low word holds accumulator bits 31:0. The high word holds bits 41:32 in its own bits 9:0, and its bits 31:10 always read back as copies of bit 9. A small command port starts each operation:

- multiply-accumulate
- clear
- load of either word from a 32-bit input
- read-back of either word onto a registered 32-bit output

Each operation has a fixed latency. A one-cycle `done` pulse marks its completion. `busy` is high while a multi-cycle operation is in flight, and a start strobe seen while `busy` is high is dropped. The unit sits beside a datapath that fetches the operands itself, so it has no memory access and no instruction decoding.

Top module: `mac_acc_unit`

## Requirements
- R1: After synchronous reset, `busy`, `done` and `dout` are 0 and the accumulator is zero, so both words read back as 0.
- R2: Command code 0 (multiply-accumulate) adds the signed product `op_a*op_b`, sign-extended to 42 bits, into the accumulator. If `start` is accepted at clock edge E, `done` is high after edge E+3, which is 4 cycles.
- R3: Accumulation wraps modulo 2^42 with no saturation, so adding 1 to the largest positive value gives -2^41.
- R4: Command code 1 clears the whole accumulator to zero, with `done` after edge E+1.
- R5: Command code 2 loads accumulator bits 41:32 from `din[9:0]` and discards `din[31:10]`. The low word is unchanged and `done` comes after edge E+1.
- R6: Command code 3 loads accumulator bits 31:0 from `din`. Bits 41:32 are unchanged and `done` comes after edge E+1.
- R7: Command code 4 puts the high word on `dout` after edge E: bits 9:0 are accumulator bits 41:32 and bits 31:10 copy bit 9. Command code 5 puts accumulator bits 31:0 on `dout` after edge E. Both reads pulse `done` after edge E and never raise `busy`.
- R8: A multi-cycle command holds `busy` high from the cycle after its accept edge up to its completion edge. Any `start` sampled while `busy` is high is ignored. `done` and `busy` are never high together.
- R9: `done` is a one-cycle pulse per accepted command, and `dout` changes only in a cycle where `done` is high. Command codes 6 and 7 are ignored: no `busy`, no `done`, and no change to the accumulator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command strobe, sampled when `busy` is low |
| cmd | input | 3 | Command code (0 MAC, 1 clear, 2 load high, 3 load low, 4 read high, 5 read low) |
| op_a | input | 16 | Signed multiplicand |
| op_b | input | 16 | Signed multiplier |
| din | input | 32 | Load data, captured at the accept edge |
| busy | output | 1 | Multi-cycle command in flight |
| done | output | 1 | One-cycle completion pulse |
| dout | output | 32 | Registered read-back word |

## Verification
Let E be the clock edge that accepts a command.

- A multiply-accumulate is due after edge E+3.
- Clear and the two loads are due after edge E+1.
- A read is due after edge E itself.

The bench drives inputs on falling edges and counts rising edges from E. At each falling edge before the due edge it requires `busy` high and `done` low, and at the due falling edge it requires `done` high and `busy` low. It compares read results only in that due cycle, against a 42-bit model that it updates arithmetically. A dropped strobe is checked by holding a clear command on the port through a whole multiply-accumulate and then reading both words back.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [2:0] {
    CMD_MAC = 3'd0,
    CMD_CLR = 3'd1,
    CMD_LDH = 3'd2,
    CMD_LDL = 3'd3,
    CMD_RDH = 3'd4,
    CMD_RDL = 3'd5
  } mac_cmd_e;

  localparam logic [2:0] CMD_LAST = 3'd5;
endpackage

// File: rtl/mac_seq.sv
// Command sequencer: accepts a strobe when idle, counts the fixed latency
// and produces the completion edge (fire) and the done pulse.
module mac_seq
  import mac_pkg::*;
#(
  parameter int LAT_MAC  = 4,
  parameter int LAT_LOAD = 2,
  parameter int LAT_READ = 1
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     start,
  input  logic [2:0] cmd,
  output logic     accept,
  output logic     fire,
  output mac_cmd_e fire_cmd,
  output logic     busy,
  output logic     done
);
  localparam int LAT_MAX = (LAT_MAC > LAT_LOAD) ? LAT_MAC : LAT_LOAD;
  localparam int CNT_W   = $clog2(LAT_MAX + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lat_sel;
  mac_cmd_e         cmd_q;

  always_comb begin
    case (cmd)
      CMD_MAC:          lat_sel = CNT_W'(LAT_MAC);
      CMD_RDH, CMD_RDL: lat_sel = CNT_W'(LAT_READ);
      default:          lat_sel = CNT_W'(LAT_LOAD);
    endcase
  end

  assign accept   = start && !busy && (cmd <= CMD_LAST);
  assign fire     = (accept && lat_sel == CNT_W'(1)) || (busy && cnt == CNT_W'(1));
  assign fire_cmd = busy ? cmd_q : mac_cmd_e'(cmd);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt   <= '0;
      cmd_q <= CMD_MAC;
    end else begin
      done <= fire;
      if (accept && lat_sel > CNT_W'(1)) begin
        busy  <= 1'b1;
        cnt   <= lat_sel - CNT_W'(1);
        cmd_q <= mac_cmd_e'(cmd);
      end else if (busy) begin
        if (cnt == CNT_W'(1)) busy <= 1'b0;
        cnt <= cnt - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/mac_mul.sv
// Registered signed multiplier; product captured at the accept edge.
module mac_mul #(
  parameter int OP_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic [OP_W-1:0]        op_a,
  input  logic [OP_W-1:0]        op_b,
  output logic signed [2*OP_W-1:0] prod
);
  always_ff @(posedge clk) begin
    if (rst)       prod <= '0;
    else if (load) prod <= $signed(op_a) * $signed(op_b);
  end
endmodule

// File: rtl/mac_acc.sv
// Accumulator storage, update on the completion edge and read-back mux.
module mac_acc
  import mac_pkg::*;
#(
  parameter int OP_W   = 16,
  parameter int WORD_W = 32,
  parameter int ACC_W  = 42
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               accept,
  input  logic               fire,
  input  mac_cmd_e           fire_cmd,
  input  logic [WORD_W-1:0]  din,
  input  logic [2*OP_W-1:0]  prod,
  output logic [WORD_W-1:0]  dout
);
  localparam int HI_W   = ACC_W - WORD_W;
  localparam int PROD_W = 2 * OP_W;

  logic [ACC_W-1:0]  acc;
  logic [ACC_W-1:0]  sum;
  logic [WORD_W-1:0] din_q;
  logic [WORD_W-1:0] hi_ext;

  assign sum    = acc + {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
  assign hi_ext = {{(WORD_W-HI_W){acc[ACC_W-1]}}, acc[ACC_W-1:WORD_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      din_q <= '0;
      dout  <= '0;
    end else begin
      if (accept) din_q <= din;
      if (fire) begin
        case (fire_cmd)
          CMD_MAC: acc <= sum;
          CMD_CLR: acc <= '0;
          CMD_LDH: acc[ACC_W-1:WORD_W] <= din_q[HI_W-1:0];
          CMD_LDL: acc[WORD_W-1:0] <= din_q;
          CMD_RDH: dout <= hi_ext;
          CMD_RDL: dout <= acc[WORD_W-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mac_acc_unit.sv
module mac_acc_unit
  import mac_pkg::*;
#(
  parameter int OP_W     = 16,
  parameter int WORD_W   = 32,
  parameter int ACC_W    = 42,
  parameter int LAT_MAC  = 4,
  parameter int LAT_LOAD = 2,
  parameter int LAT_READ = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        cmd,
  input  logic [OP_W-1:0]   op_a,
  input  logic [OP_W-1:0]   op_b,
  input  logic [WORD_W-1:0] din,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] dout
);
  logic                   accept;
  logic                   fire;
  mac_cmd_e               fire_cmd;
  logic [2*OP_W-1:0]      prod;

  mac_seq #(
    .LAT_MAC (LAT_MAC),
    .LAT_LOAD(LAT_LOAD),
    .LAT_READ(LAT_READ)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .cmd     (cmd),
    .accept  (accept),
    .fire    (fire),
    .fire_cmd(fire_cmd),
    .busy    (busy),
    .done    (done)
  );

  mac_mul #(.OP_W(OP_W)) u_mul (
    .clk (clk),
    .rst (rst),
    .load(accept),
    .op_a(op_a),
    .op_b(op_b),
    .prod(prod)
  );

  mac_acc #(
    .OP_W  (OP_W),
    .WORD_W(WORD_W),
    .ACC_W (ACC_W)
  ) u_acc (
    .clk     (clk),
    .rst     (rst),
    .accept  (accept),
    .fire    (fire),
    .fire_cmd(fire_cmd),
    .din     (din),
    .prod    (prod),
    .dout    (dout)
  );
endmodule

// File: rtl/mac_acc_unit_chk.sv
module mac_acc_unit_chk #(
  parameter int WORD_W   = 32,
  parameter int HI_W     = 10,
  parameter int LAT_MAC  = 4,
  parameter int LAT_LOAD = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [2:0]        cmd,
  input logic              busy,
  input logic              done,
  input logic [WORD_W-1:0] dout
);
  logic [2:0] last_cmd;
  logic [3:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_cmd <= 3'd0;
      run      <= '0;
    end else begin
      if (start && !busy && cmd <= 3'd5) last_cmd <= cmd;
      if (!busy)            run <= '0;
      else if (run != 4'hF) run <= run + 4'd1;
    end
  end

  // R2: multiply-accumulate busy for exactly LAT_MAC-1 sampled cycles
  p_mac_len_r2: assert property (@(posedge clk) disable iff (rst)
    (done && last_cmd == 3'd0) |-> (run == 4'(LAT_MAC - 1)));

  // R4 R5 R6: clear and loads busy for LAT_LOAD-1 cycles
  p_load_len_r4: assert property (@(posedge clk) disable iff (rst)
    (done && last_cmd >= 3'd1 && last_cmd <= 3'd3) |-> (run == 4'(LAT_LOAD - 1)));

  // R7: high word read is sign-extended from bit HI_W-1
  p_hi_sext_r7: assert property (@(posedge clk) disable iff (rst)
    (done && last_cmd == 3'd4) |-> (dout[WORD_W-1:HI_W] == {(WORD_W-HI_W){dout[HI_W-1]}}));

  // R7: reads never raise busy
  p_read_nobusy_r7: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && cmd >= 3'd4 && cmd <= 3'd5) |=> !busy);

  // R8: done and busy exclusive
  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R8: multi-cycle command raises busy
  p_accept_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && cmd <= 3'd3) |=> busy);

  // R9: dout moves only with done
  p_dout_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(dout));

  // R9: undefined codes ignored
  p_bad_code_r9: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && cmd > 3'd5) |=> (!busy && !done));
endmodule

bind mac_acc_unit mac_acc_unit_chk #(
  .WORD_W  (WORD_W),
  .HI_W    (ACC_W - WORD_W),
  .LAT_MAC (LAT_MAC),
  .LAT_LOAD(LAT_LOAD)
) u_chk (
  .clk  (clk),
  .rst  (rst),
  .start(start),
  .cmd  (cmd),
  .busy (busy),
  .done (done),
  .dout (dout)
);

// File: tb/mac_acc_unit_bench.sv
module mac_acc_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  cmd = 3'd0;
  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;
  logic [31:0] din = '0;
  logic        busy;
  logic        done;
  logic [31:0] dout;

  int          n_chk = 0;
  int          n_fail = 0;
  logic [41:0] model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_acc_unit u_mac_acc_unit (
    .clk(clk), .rst(rst), .start(start), .cmd(cmd), .op_a(op_a),
    .op_b(op_b), .din(din), .busy(busy), .done(done), .dout(dout)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic int lat_of(input logic [2:0] c);
    if (c == 3'd0) return 4;
    if (c >= 3'd4) return 1;
    return 2;
  endfunction

  // Issue a command at a falling edge; return at the falling edge after done.
  task automatic issue(input logic [2:0] c, input logic [15:0] a,
                       input logic [15:0] b, input logic [31:0] d);
    int lat;
    lat = lat_of(c);
    start = 1'b1; cmd = c; op_a = a; op_b = b; din = d;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    for (int i = 1; i < lat; i++) begin
      chk(busy && !done, "R8 busy during op", {62'd0, busy, done}, 64'd2);
      @(posedge clk); @(negedge clk);
    end
    chk(done && !busy, "R9 done at due cycle", {62'd0, busy, done}, 64'd1);
  endtask

  task automatic do_mac(input logic [15:0] a, input logic [15:0] b);
    logic signed [15:0] sa;
    logic signed [15:0] sb;
    logic signed [31:0] p;
    sa = a; sb = b; p = sa * sb;
    issue(3'd0, a, b, 32'd0);
    model = model + {{10{p[31]}}, p};
  endtask

  task automatic rd_check(input string req);
    logic [31:0] exp_hi;
    issue(3'd5, 16'd0, 16'd0, 32'd0);
    chk(dout == model[31:0], {req, " R7 low read"}, {32'd0, dout}, {32'd0, model[31:0]});
    exp_hi = {{22{model[41]}}, model[41:32]};
    issue(3'd4, 16'd0, 16'd0, 32'd0);
    chk(dout == exp_hi, {req, " R7 high read"}, {32'd0, dout}, {32'd0, exp_hi});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    logic [15:0] vals [8];
    vals = '{16'h8000, 16'h8001, 16'hFFFF, 16'h0000, 16'h0001, 16'h0002,
             16'h3039, 16'h7FFF};
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1
    chk(!busy && !done && dout == 0, "R1 reset outputs",
        {31'd0, busy, done, dout}, 64'd0);
    rd_check("R1");

    // R2 sweep of all operand pairs
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) do_mac(vals[i], vals[j]);
      rd_check("R2");
    end

    // R4 clear
    issue(3'd1, 16'd0, 16'd0, 32'hDEADBEEF); model = '0;
    rd_check("R4");

    // R5 high load drops upper bits; negative then positive
    issue(3'd2, 16'd0, 16'd0, 32'hABCDE3FF); model[41:32] = 10'h3FF;
    rd_check("R5");
    issue(3'd2, 16'd0, 16'd0, 32'hFFFFF955); model[41:32] = 10'h155;
    rd_check("R5");

    // R6 low load leaves high bits
    issue(3'd3, 16'd0, 16'd0, 32'h12345678); model[31:0] = 32'h12345678;
    rd_check("R6");

    // R3 wrap at largest positive value
    issue(3'd2, 16'd0, 16'd0, 32'h000001FF); model[41:32] = 10'h1FF;
    issue(3'd3, 16'd0, 16'd0, 32'hFFFFFFFF); model[31:0] = 32'hFFFFFFFF;
    do_mac(16'd1, 16'd1);
    chk(model == 42'h200_0000_0000, "R3 model wrap", {22'd0, model}, 64'h200_0000_0000);
    rd_check("R3");
    do_mac(16'hFFFF, 16'h0001);
    rd_check("R3");

    // R8 strobe held with clear code during a MAC is ignored
    start = 1'b1; cmd = 3'd0; op_a = 16'd100; op_b = 16'hFFF6;
    @(posedge clk); @(negedge clk);
    cmd = 3'd1;
    for (int k = 0; k < 3; k++) begin
      chk(busy && !done, "R8 busy with held strobe", {62'd0, busy, done}, 64'd2);
      @(posedge clk); @(negedge clk);
    end
    chk(done && !busy, "R8 done while strobe held", {62'd0, busy, done}, 64'd1);
    start = 1'b0;
    model = model + {{10{1'b1}}, 32'hFFFFFC18};
    @(posedge clk); @(negedge clk);
    chk(!done && !busy, "R9 done single pulse", {62'd0, busy, done}, 64'd0);
    rd_check("R8");

    // R9 undefined codes ignored
    for (int c = 6; c < 8; c++) begin
      start = 1'b1; cmd = 3'(c); din = 32'hFFFFFFFF;
      @(posedge clk); @(negedge clk);
      start = 1'b0;
      chk(!busy && !done, "R9 undefined code", {62'd0, busy, done}, 64'd0);
      @(posedge clk); @(negedge clk);
      chk(!busy && !done, "R9 undefined code later", {62'd0, busy, done}, 64'd0);
    end
    rd_check("R9");

    summary();
  end
endmodule